// File: doc/BRIEF.md
# Two-Level Longest-Prefix Lookup Pipeline

This block resolves a 32-bit IPv4 destination address to a next-hop identifier. It uses prefixes that software has already expanded into two directly indexed tables, so no trie walk or associative search is needed. The first table is indexed by the 24-bit prefix of the address. Each entry in it holds either a final next hop or a pointer to a 256-entry block in a second table. When the entry is a pointer, the low address byte selects one byte-wide next hop inside that block.

The two tables are separate synchronous RAMs inside the block, and each read takes one pipeline stage. A new address can therefore enter on every clock, and each result appears two cycles after its address. Results leave in arrival order, and each carries a sideband tag that the caller supplied with the address.

Each table has a single-cycle write port for the processor that loads it. The first-table index width is a parameter, so a small table can stand in for the full 2^24-entry one.

Top module: `lpm_lookup_top`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `out_valid` is low.
- R2: Each address accepted at a clock edge (`in_valid` and `in_ready` high) produces exactly one result, with `out_valid` high during the cycle after the second following edge. No result appears without an accepted address.
- R3: A first-table entry is 16 bits wide, and bit 15 is the indirection flag. When the flag is 0, `out_hop` equals bits 14:0 of the entry.
- R4: When the flag is 1, the second-table address is {entry bits PTR_W-1:0, address bits 7:0}, and the other payload bits are ignored. `out_hop` is then that 8-bit second-table entry zero-extended to 15 bits.
- R5: The first-table index is address bits IDX_W+7:8. Address bits above that field do not affect the result.
- R6: Back-to-back lookups are accepted on consecutive cycles. Their results come out on consecutive cycles in arrival order, each with the tag that entered with its address.
- R7: If a table write and a lookup read of the same entry happen in the same cycle, the lookup returns the old contents. A later lookup returns the new contents.
- R8: With a /16 route A, a /24 route B inside it and a /26 route C inside B (the upper quarter of B's block), a host in C's range resolves to C. Other hosts in B's block resolve to B, and addresses elsewhere in A resolve to A.
- R9: `in_ready` is high whenever reset is not asserted. The pipeline never stalls its input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Address present |
| in_ready | output | 1 | Block accepts an address |
| in_addr | input | 32 | Destination address |
| in_tag | input | TAG_W | Sideband tag carried with the address |
| out_valid | output | 1 | Result present |
| out_hop | output | 15 | Next-hop identifier |
| out_tag | output | TAG_W | Tag of the address this result belongs to |
| t1_we | input | 1 | First-table write enable |
| t1_waddr | input | IDX_W | First-table write index |
| t1_wdata | input | 16 | First-table entry: flag in bit 15, payload in bits 14:0 |
| t2_we | input | 1 | Second-table write enable |
| t2_waddr | input | PTR_W+8 | Second-table write address |
| t2_wdata | input | 8 | Second-table next hop |

## Verification
The bench loads a nested three-route set and probes hosts on both sides of the /26 boundary inside the /24 block and outside it. These probes separate a result taken from the first table from one taken from the second, and an off-by-one in the low-byte concatenation. Two more patterns cover payload handling. A pointer entry with stray high payload bits checks that only the pointer field forms the address. Flag-0 entries holding all-ones and all-zeros payloads check zero extension and width. A run of back-to-back lookups with distinct tags checks ordering and tag alignment. Writes timed to land on the very cycle each table is read tell old-data from new-data behaviour.

// File: rtl/lpm_pkg.sv
// Shared types and constants for the longest-prefix lookup pipeline.
// Assumes a 15-bit next-hop space and an 8-bit low-address field.
package lpm_pkg;
    localparam int HOP_W  = 15;
    localparam int LOW_W  = 8;
    localparam int T2_DW  = 8;
    localparam int T1_DW  = HOP_W + 1;

    // First-table entry: indirection flag over a 15-bit payload.
    typedef struct packed {
        logic             ext;
        logic [HOP_W-1:0] payload;
    } t1_entry_t;
endpackage

// File: rtl/lpm_ram.sv
// Synchronous single-read, single-write RAM.
// Assumes one write and one read per cycle; a read of the address being
// written returns the previous contents. Contents are not reset.
module lpm_ram #(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Write port: store new data on enable.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read port: registered read, old data on collision.
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/lpm_entry_decode.sv
// Splits a first-table entry and forms the second-table read address.
// Assumes the block pointer lives in the low PTR_W payload bits.
module lpm_entry_decode
    import lpm_pkg::*;
#(
    parameter int PTR_W = 3
) (
    input  t1_entry_t              entry,
    input  logic [LOW_W-1:0]       low_byte,
    output logic                   need_t2,
    output logic [HOP_W-1:0]       direct_hop,
    output logic [PTR_W+LOW_W-1:0] t2_raddr
);
    // Decode: flag selects indirection, pointer concatenated with low byte.
    always_comb begin
        need_t2    = entry.ext;
        direct_hop = entry.payload;
        t2_raddr   = {entry.payload[PTR_W-1:0], low_byte};
    end
endmodule

// File: rtl/lpm_hop_select.sv
// Chooses the final next hop from the first-table payload or the
// zero-extended second-table byte.
module lpm_hop_select
    import lpm_pkg::*;
(
    input  logic             use_t2,
    input  logic [HOP_W-1:0] direct_hop,
    input  logic [T2_DW-1:0] t2_hop,
    output logic [HOP_W-1:0] hop
);
    // Select: second-table result is widened with zeros.
    always_comb begin
        hop = use_t2 ? {{(HOP_W-T2_DW){1'b0}}, t2_hop} : direct_hop;
    end
endmodule

// File: rtl/lpm_lookup_top.sv
// Two-stage longest-prefix lookup. Stage one reads the first table with
// the prefix index, stage two reads the second table when flagged.
// Assumes tables are loaded through the write ports before use.
module lpm_lookup_top
    import lpm_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int PTR_W = 3,
    parameter int TAG_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [31:0]            in_addr,
    input  logic [TAG_W-1:0]       in_tag,
    output logic                   out_valid,
    output logic [HOP_W-1:0]       out_hop,
    output logic [TAG_W-1:0]       out_tag,
    input  logic                   t1_we,
    input  logic [IDX_W-1:0]       t1_waddr,
    input  logic [T1_DW-1:0]       t1_wdata,
    input  logic                   t2_we,
    input  logic [PTR_W+LOW_W-1:0] t2_waddr,
    input  logic [T2_DW-1:0]       t2_wdata
);
    localparam int T2_AW = PTR_W + LOW_W;

    logic                accept;
    logic [IDX_W-1:0]    t1_raddr;
    logic [T1_DW-1:0]    t1_rdata;
    t1_entry_t           s1_entry;
    logic                s1_valid;
    logic [TAG_W-1:0]    s1_tag;
    logic [LOW_W-1:0]    s1_low;
    logic                s1_need_t2;
    logic [HOP_W-1:0]    s1_direct;
    logic [T2_AW-1:0]    t2_raddr;
    logic [T2_DW-1:0]    t2_rdata;
    logic                s2_valid;
    logic [TAG_W-1:0]    s2_tag;
    logic                s2_ext;
    logic [HOP_W-1:0]    s2_direct;

    // Input side: never stalls outside reset.
    always_comb begin
        in_ready = rst_n;
        accept   = in_valid && in_ready;
        t1_raddr = in_addr[IDX_W+LOW_W-1:LOW_W];
        s1_entry = t1_entry_t'(t1_rdata);
    end

    lpm_ram #(.DW(T1_DW), .AW(IDX_W)) u_t1 (
        .clk   (clk),
        .we    (t1_we),
        .waddr (t1_waddr),
        .wdata (t1_wdata),
        .raddr (t1_raddr),
        .rdata (t1_rdata)
    );

    // Stage one control: valid, tag and low byte alongside the first read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_tag   <= '0;
            s1_low   <= '0;
        end else begin
            s1_valid <= accept;
            s1_tag   <= in_tag;
            s1_low   <= in_addr[LOW_W-1:0];
        end
    end

    lpm_entry_decode #(.PTR_W(PTR_W)) u_dec (
        .entry      (s1_entry),
        .low_byte   (s1_low),
        .need_t2    (s1_need_t2),
        .direct_hop (s1_direct),
        .t2_raddr   (t2_raddr)
    );

    lpm_ram #(.DW(T2_DW), .AW(T2_AW)) u_t2 (
        .clk   (clk),
        .we    (t2_we),
        .waddr (t2_waddr),
        .wdata (t2_wdata),
        .raddr (t2_raddr),
        .rdata (t2_rdata)
    );

    // Stage two control: carry decode results alongside the second read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid  <= 1'b0;
            s2_tag    <= '0;
            s2_ext    <= 1'b0;
            s2_direct <= '0;
        end else begin
            s2_valid  <= s1_valid;
            s2_tag    <= s1_tag;
            s2_ext    <= s1_need_t2;
            s2_direct <= s1_direct;
        end
    end

    lpm_hop_select u_sel (
        .use_t2     (s2_ext),
        .direct_hop (s2_direct),
        .t2_hop     (t2_rdata),
        .hop        (out_hop)
    );

    // Output side: result flag and tag.
    always_comb begin
        out_valid = s2_valid;
        out_tag   = s2_tag;
    end
endmodule

// File: rtl/lpm_lookup_chk.sv
// Timing and ordering checks for lpm_lookup_top, bound to every instance.
// Keeps its own two-deep record of accepted lookups and their tags.
module lpm_lookup_chk #(
    parameter int TAG_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [TAG_W-1:0] in_tag,
    input logic             out_valid,
    input logic [14:0]      out_hop,
    input logic [TAG_W-1:0] out_tag,
    input logic             s2_ext
);
    logic             seen1, seen2;
    logic [TAG_W-1:0] tag1, tag2;

    // Record accepted lookups two cycles deep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen1 <= 1'b0;
            seen2 <= 1'b0;
            tag1  <= '0;
            tag2  <= '0;
        end else begin
            seen1 <= in_valid && in_ready;
            seen2 <= seen1;
            tag1  <= in_tag;
            tag2  <= tag1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !out_valid);

    // R2
    latency_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == seen2);

    // R6
    tag_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_tag == tag2);

    // R4
    zero_extend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && s2_ext) |-> out_hop[14:8] == 7'd0);
endmodule

bind lpm_lookup_top lpm_lookup_chk #(.TAG_W(TAG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_tag    (in_tag),
    .out_valid (out_valid),
    .out_hop   (out_hop),
    .out_tag   (out_tag),
    .s2_ext    (s2_ext)
);

// File: tb/sim_lpm_lookup_top.sv
// Scoreboard bench: driver pushes expected results, monitor compares.
module sim_lpm_lookup_top;
    localparam int IDX_W = 10;
    localparam int PTR_W = 3;
    localparam int TAG_W = 4;
    localparam int T2_AW = PTR_W + 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [31:0]      in_addr = '0;
    logic [TAG_W-1:0] in_tag = '0;
    logic             out_valid;
    logic [14:0]      out_hop;
    logic [TAG_W-1:0] out_tag;
    logic             t1_we = 1'b0;
    logic [IDX_W-1:0] t1_waddr = '0;
    logic [15:0]      t1_wdata = '0;
    logic             t2_we = 1'b0;
    logic [T2_AW-1:0] t2_waddr = '0;
    logic [7:0]       t2_wdata = '0;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    logic [15:0] sh1 [1 << IDX_W];
    logic [7:0]  sh2 [1 << T2_AW];

    typedef struct packed {
        logic [14:0]      hop;
        logic [TAG_W-1:0] tag;
        logic [7:0]       req;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    lpm_lookup_top #(.IDX_W(IDX_W), .PTR_W(PTR_W), .TAG_W(TAG_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_tag(in_tag), .out_valid(out_valid),
        .out_hop(out_hop), .out_tag(out_tag), .t1_we(t1_we),
        .t1_waddr(t1_waddr), .t1_wdata(t1_wdata), .t2_we(t2_we),
        .t2_waddr(t2_waddr), .t2_wdata(t2_wdata)
    );

    function automatic logic [14:0] model_hop(input logic [31:0] a);
        logic [15:0] e;
        e = sh1[a[IDX_W+7:8]];
        if (e[15]) return {7'd0, sh2[{e[PTR_W-1:0], a[7:0]}]};
        return e[14:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic wr1(input int idx, input logic [15:0] d);
        t1_we = 1'b1; t1_waddr = idx[IDX_W-1:0]; t1_wdata = d;
        sh1[idx] = d;
        @(negedge clk);
        t1_we = 1'b0;
    endtask

    task automatic wr2(input int a, input logic [7:0] d);
        t2_we = 1'b1; t2_waddr = a[T2_AW-1:0]; t2_wdata = d;
        sh2[a] = d;
        @(negedge clk);
        t2_we = 1'b0;
    endtask

    // Drive one lookup; expected value taken from the shadow tables now.
    task automatic look(input logic [31:0] a, input logic [TAG_W-1:0] t,
                        input logic [7:0] req);
        exp_t x;
        x.hop = model_hop(a); x.tag = t; x.req = req;
        q.push_back(x);
        in_valid = 1'b1; in_addr = a; in_tag = t;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: compare each result with the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R2 actual=unexpected result expected=none");
            end else begin
                exp_t x;
                x = q.pop_front();
                check($sformatf("R%0d hop", x.req), {17'd0, out_hop}, {17'd0, x.hop});
                check("R6 tag", {28'd0, out_tag}, {28'd0, x.tag});
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [3:0] tg;
        tg = 0;
        repeat (3) @(negedge clk);
        // R1: quiet in reset
        check("R1", {31'd0, out_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {31'd0, out_valid}, 32'd0);
        // R9: input always ready
        check("R9", {31'd0, in_ready}, 32'd1);

        // Route A = 10.54/16 (hop 0x1234) covers indices 512..767; index 546 points to block 5.
        for (int i = 512; i < 768; i++) wr1(i, (i == 546) ? 16'h8005 : 16'h1234);
        // B for hosts 0..191, C for 192..255 in block 5.
        for (int j = 0; j < 256; j++) wr2(5 * 256 + j, (j < 192) ? 8'h42 : 8'h77);
        // Index 0: pointer with stray payload bits, low three bits give block 5.
        wr1(0, 16'h8105);
        // Flag-0 extremes.
        wr1(1, 16'h7FFF);
        wr1(2, 16'h0000);

        // R8: nested routes
        look(32'h0A3622C2, tg++, 8);   // 10.54.34.194 -> C
        look(32'h0A362217, tg++, 8);   // 10.54.34.23 -> B
        look(32'h0A361693, tg++, 8);   // 10.54.22.147 -> A
        look(32'h0A3622BF, tg++, 4);   // R4 boundary host 191 -> B
        look(32'h0A3622C0, tg++, 4);   // R4 boundary host 192 -> C
        // R5: upper bits ignored
        look(32'h633622C2, tg++, 5);
        // R4: stray payload bits ignored
        look(32'h000000C8, tg++, 4);
        // R3: flag-0 all-ones and zero payloads
        look(32'h00000155, tg++, 3);
        look(32'h00000201, tg++, 3);
        repeat (4) @(negedge clk);

        // R6: burst with distinct tags, no gaps
        for (int k = 0; k < 8; k++)
            look({8'h0A, 8'h36, (k[0] ? 8'h22 : 8'h05), k[7:0] * 8'd37}, tg++, 6);
        repeat (4) @(negedge clk);

        // R7: first-table write in the read cycle returns old entry
        t1_we = 1'b1; t1_waddr = 10'd1; t1_wdata = 16'h0ABC;
        look(32'h00000100, tg++, 7);
        sh1[1] = 16'h0ABC;
        t1_we = 1'b0;
        look(32'h00000100, tg++, 7);
        // R7: second-table write in its read cycle returns old byte
        look(32'h0A362210, tg++, 7);
        wr2(5 * 256 + 16, 8'hE5);
        look(32'h0A362210, tg++, 7);
        repeat (5) @(negedge clk);

        // R2: every lookup produced exactly one result
        check("R2", q.size(), 32'd0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule